// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block turns single-word requests from a synchronous request port into strobed cycles on a DRAM with a multiplexed address bus. A full `ADDR_W`-bit address goes out on an `ADDR_W/2`-bit bus in two halves. The upper half is the row and goes out first under the active-low row strobe. The lower half is the column and follows under the active-low column strobe. Writes drive the data bus and pull the active-low write strobe during the column phase. Reads leave the bus undriven and capture the DRAM's data at the end of the column pulse. The captured word is returned on the request port with a one-cycle valid pulse.

A refresh scheduler raises a pending flag every `RETENTION_CLKS / 2^(ADDR_W/2)` clocks. This spreads refreshes so that all rows are revisited within the retention period. A pending refresh is served before any new request but never cuts into an access that is already running. A refresh cycle is row-only: it puts the next row from a wrapping counter on the bus and pulses the row strobe, while the column strobe, write strobe and data bus stay idle.

The state machine has these states:
- `ST_IDLE`
- `ST_ROW_SETUP`: row on the bus, strobes high
- `ST_ROW_HOLD`: row strobe low, row held
- `ST_COL_SETUP`: column on the bus
- `ST_COL_STROBE`: column strobe low
- `ST_REF_SETUP`
- `ST_REF_STROBE`
- `ST_PRECHARGE`: both strobes high

It has these transitions:
- `ST_IDLE` goes to `ST_REF_SETUP` when a refresh is pending, otherwise to `ST_ROW_SETUP` on an accepted request.
- `ST_ROW_SETUP` goes to `ST_ROW_HOLD`, then to `ST_COL_SETUP` and then to `ST_COL_STROBE`, each after its timer expires.
- `ST_COL_STROBE` goes to `ST_PRECHARGE`.
- `ST_REF_SETUP` goes to `ST_REF_STROBE`, and `ST_REF_STROBE` goes to `ST_PRECHARGE`.
- `ST_PRECHARGE` returns to `ST_IDLE`.

Each phase lasts `T_SETUP`, `T_RCD`, 1, `T_CAS`, `T_RCD+T_CAS` or `T_PRE` clocks, as listed below.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row half `req_addr[ADDR_W-1:ADDR_W/2]` is on `mem_addr` when `mem_ras_n` falls, and the column half `req_addr[ADDR_W/2-1:0]` is on it when `mem_cas_n` falls. Each half is stable for at least one cycle before its strobe falls.
- R2: In a write, `mem_we_n` is low and `mem_dq_oe` is high with `mem_dq_out` equal to the request's write data while `mem_cas_n` is low. The addressed DRAM word then holds that data.
- R3: In a read, `mem_we_n` stays high and `mem_dq_oe` stays low. `rsp_valid` is high for exactly one cycle, the (T_SETUP+T_RCD+T_CAS+2)th cycle after the accepting edge, and `rsp_rdata` then carries the word stored at the address.
- R4: In an access, `mem_ras_n` is low for exactly T_RCD+1 cycles before `mem_cas_n` falls, and `mem_cas_n` stays low for exactly T_CAS cycles. `mem_cas_n` is never low while `mem_ras_n` is high.
- R5: `mem_ras_n` and `mem_cas_n` rise in the same cycle at the end of an access. `mem_ras_n` then stays high for at least T_PRE cycles before it falls again.
- R6: A refresh cycle holds `mem_ras_n` low for exactly T_RCD+T_CAS cycles. During it, `mem_cas_n` and `mem_we_n` stay high and `mem_dq_oe` stays low.
- R7: Refresh row addresses run 0, 1, 2, … from reset and wrap to 0 after row 2^(ADDR_W/2)-1.
- R8: A refresh is issued every RETENTION_CLKS/2^(ADDR_W/2) clocks. It wins over a waiting request, so the gap between consecutive refresh row strobes stays within that interval plus twice the length of one access, even under back-to-back traffic.
- R9: `req_ready` goes low on the cycle after a request is accepted. It stays low through the end of precharge, for T_SETUP+T_RCD+T_CAS+T_PRE+1 cycles.
- R10: After reset, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W/2 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Data driven to the DRAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench writes to addresses whose two halves differ, such as 0x0F and 0xF0, and reads them back through a strobe-decoding memory model. A controller that swapped row and column would therefore store data at the wrong word. Back-to-back random traffic keeps `req_valid` high so that refresh must win arbitration. A refresh scheduler that let requests starve it would stretch the refresh gap past its bound, and a row counter that skipped or did not wrap would break the row sequence. Exact counts of strobe widths, read latency and busy time expose any phase that is off by one cycle. A precharge that was cut short, or that let RAS fall too early, fails the high-time check.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_ROW_HOLD,
        ST_COL_SETUP,
        ST_COL_STROBE,
        ST_REF_SETUP,
        ST_REF_STROBE,
        ST_PRECHARGE
    } ctrl_state_e;

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int ROW_W    = 4,
    parameter int INTERVAL = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             finish,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] TICK_AT = TW'(INTERVAL - 1);

    logic [TW-1:0]    tmr_q;
    logic             tick;
    logic             pend_q;
    logic [ROW_W-1:0] row_q;

    assign tick = (tmr_q == TICK_AT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // a new tick keeps the flag set even if a refresh starts in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= tick | (pend_q & ~start);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (finish) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign pending = pend_q;
    assign row     = row_q;

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 8,
    parameter int T_SETUP        = 1,
    parameter int T_RCD          = 2,
    parameter int T_CAS          = 2,
    parameter int T_PRE          = 2,
    parameter int RETENTION_CLKS = 768
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W/2-1:0] mem_addr,
    output logic                mem_ras_n,
    output logic                mem_cas_n,
    output logic                mem_we_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);

    localparam int HALF_W       = ADDR_W / 2;
    localparam int ROWS         = 1 << HALF_W;
    localparam int REF_INTERVAL = RETENTION_CLKS / ROWS;
    localparam int T_REF        = T_RCD + T_CAS;
    localparam int MAX_A        = (T_SETUP > T_PRE) ? T_SETUP : T_PRE;
    localparam int MAX_T        = (MAX_A > T_REF) ? MAX_A : T_REF;
    localparam int CNT_W        = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_CAS   = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] LD_REF   = CNT_W'(T_REF - 1);
    localparam logic [CNT_W-1:0] LD_PRE   = CNT_W'(T_PRE - 1);

    ctrl_state_e state_q, state_d;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              accept;
    logic              ref_start;
    logic              ref_finish;
    logic              ref_pending;
    logic [HALF_W-1:0] ref_row;
    logic              cap_rd;

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    dram_phase_timer #(
        .CNT_W(CNT_W)
    ) phase_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    dram_refresh_sched #(
        .ROW_W   (HALF_W),
        .INTERVAL(REF_INTERVAL)
    ) ref_sched_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ref_start),
        .finish (ref_finish),
        .pending(ref_pending),
        .row    (ref_row)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase timer loads
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        ref_start  = 1'b0;
        ref_finish = 1'b0;
        cap_rd     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d   = ST_REF_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_SETUP;
                    ref_start = 1'b1;
                end else if (req_valid) begin
                    state_d  = ST_ROW_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                    accept   = 1'b1;
                end
            end
            ST_ROW_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_ROW_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RCD;
                end
            end
            ST_ROW_HOLD: begin
                if (tmr_last) begin
                    state_d  = ST_COL_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = '0;
                end
            end
            ST_COL_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_COL_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CAS;
                end
            end
            ST_COL_STROBE: begin
                if (tmr_last) begin
                    state_d  = ST_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PRE;
                    cap_rd   = ~wr_q;
                end
            end
            ST_REF_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_REF_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_REF;
                end
            end
            ST_REF_STROBE: begin
                if (tmr_last) begin
                    state_d    = ST_PRECHARGE;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_PRE;
                    ref_finish = 1'b1;
                end
            end
            ST_PRECHARGE: begin
                if (tmr_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= cap_rd;
            if (cap_rd) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    // strobe and bus decode from state
    always_comb begin
        mem_addr  = '0;
        mem_ras_n = 1'b1;
        mem_cas_n = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRECHARGE: begin
                mem_addr = '0;
            end
            ST_ROW_SETUP: begin
                mem_addr = addr_q[ADDR_W-1:HALF_W];
            end
            ST_ROW_HOLD: begin
                mem_addr  = addr_q[ADDR_W-1:HALF_W];
                mem_ras_n = 1'b0;
            end
            ST_COL_SETUP: begin
                mem_addr  = addr_q[HALF_W-1:0];
                mem_ras_n = 1'b0;
                mem_we_n  = ~wr_q;
                mem_dq_oe = wr_q;
            end
            ST_COL_STROBE: begin
                mem_addr  = addr_q[HALF_W-1:0];
                mem_ras_n = 1'b0;
                mem_cas_n = 1'b0;
                mem_we_n  = ~wr_q;
                mem_dq_oe = wr_q;
            end
            ST_REF_SETUP: begin
                mem_addr = ref_row;
            end
            ST_REF_STROBE: begin
                mem_addr  = ref_row;
                mem_ras_n = 1'b0;
            end
            default: mem_addr = '0;
        endcase
    end

    assign mem_dq_out = wdata_q;
    assign req_ready  = (state_q == ST_IDLE) && !ref_pending;
    assign rsp_valid  = rsp_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
    parameter int HALF_W = 4,
    parameter int T_PRE  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [HALF_W-1:0] mem_addr,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    localparam int HW = $clog2(T_PRE + 1);

    logic [HW-1:0] hi_cnt;

    // reset value: strobes idle high through reset, so the first cycle needs no precharge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= HW'(T_PRE);
        end else if (!mem_ras_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HW'(T_PRE)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R1
    row_addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> $stable(mem_addr));

    // R1
    col_addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> $stable(mem_addr));

    // R4
    cas_within_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> !mem_ras_n);

    // R2
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ras_n && mem_dq_oe));

    // R3
    drive_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    // R5
    precharge_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (hi_cnt >= HW'(T_PRE)));

    // R5
    strobes_rise_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cas_n) |-> $rose(mem_ras_n));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(
    .HALF_W(ADDR_W / 2),
    .T_PRE (T_PRE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n),
    .mem_we_n (mem_we_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;

    localparam int ADDR_W         = 8;
    localparam int DATA_W         = 8;
    localparam int HALF_W         = ADDR_W / 2;
    localparam int T_SETUP        = 1;
    localparam int T_RCD          = 2;
    localparam int T_CAS          = 2;
    localparam int T_PRE          = 2;
    localparam int RETENTION_CLKS = 768;
    localparam int ROWS           = 1 << HALF_W;
    localparam int REF_INTERVAL   = RETENTION_CLKS / ROWS;
    localparam int LAT_RD         = T_SETUP + T_RCD + T_CAS + 2;
    localparam int BUSY           = T_SETUP + T_RCD + T_CAS + T_PRE + 1;
    localparam int REF_BOUND      = REF_INTERVAL + 2 * (T_SETUP + T_RCD + T_CAS + T_PRE + 2);

    logic                clk;
    logic                rst_n;
    logic                req_valid;
    logic                req_ready;
    logic                req_write;
    logic [ADDR_W-1:0]   req_addr;
    logic [DATA_W-1:0]   req_wdata;
    logic                rsp_valid;
    logic [DATA_W-1:0]   rsp_rdata;
    logic [HALF_W-1:0]   mem_addr;
    logic                mem_ras_n;
    logic                mem_cas_n;
    logic                mem_we_n;
    logic [DATA_W-1:0]   mem_dq_out;
    logic                mem_dq_oe;
    logic [DATA_W-1:0]   mem_dq_in;

    int n_checks;
    int n_fails;
    int mon_checks;
    int mon_fails;
    int ref_count;
    bit timed_out;

    logic [DATA_W-1:0] model_mem [ROWS*ROWS];
    logic [DATA_W-1:0] exp_mem   [ROWS*ROWS];

    dram_mux_ctrl #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .T_SETUP       (T_SETUP),
        .T_RCD         (T_RCD),
        .T_CAS         (T_CAS),
        .T_PRE         (T_PRE),
        .RETENTION_CLKS(RETENTION_CLKS)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_in (mem_dq_in)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // DRAM model and strobe timing monitor, sampled on the falling edge
    logic              prev_ras, prev_cas;
    logic [HALF_W-1:0] row_lat, col_lat;
    int                ras_low, cas_low, pre_hi, cyc, fall_cyc, last_ref_cyc;
    bit                cas_seen, side_seen;
    logic [HALF_W-1:0] exp_ref_row;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras     = 1'b1;
            prev_cas     = 1'b1;
            row_lat      = '0;
            col_lat      = '0;
            ras_low      = 0;
            cas_low      = 0;
            pre_hi       = 1000;
            cyc          = 0;
            fall_cyc     = 0;
            last_ref_cyc = 0;
            cas_seen     = 1'b0;
            side_seen    = 1'b0;
            exp_ref_row  = '0;
            ref_count    = 0;
            mem_dq_in    = '0;
            for (int i = 0; i < ROWS*ROWS; i++) model_mem[i] = '0;
        end else begin
            cyc++;
            if (prev_ras && !mem_ras_n) begin
                row_lat   = mem_addr;
                ras_low   = 0;
                cas_seen  = 1'b0;
                side_seen = 1'b0;
                fall_cyc  = cyc;
                mon_checks++;
                if (pre_hi < T_PRE) begin
                    mon_fails++;
                    $display("FAIL R5 RAS high time before fall: got %0d expected >= %0d", pre_hi, T_PRE);
                end
            end
            if (!mem_ras_n) begin
                ras_low++;
                if (!mem_we_n || mem_dq_oe) side_seen = 1'b1;
            end
            if (prev_cas && !mem_cas_n) begin
                col_lat  = mem_addr;
                cas_seen = 1'b1;
                cas_low  = 0;
                mon_checks++;
                if (ras_low != T_RCD + 2) begin
                    mon_fails++;
                    $display("FAIL R4 RAS low cycles at CAS fall: got %0d expected %0d", ras_low - 1, T_RCD + 1);
                end
                if (!mem_we_n) begin
                    mon_checks++;
                    if (!mem_dq_oe) begin
                        mon_fails++;
                        $display("FAIL R2 write data not driven: oe got %0b expected 1", mem_dq_oe);
                    end
                    model_mem[{row_lat, col_lat}] = mem_dq_out;
                end
            end
            if (!mem_cas_n) begin
                cas_low++;
                mem_dq_in = model_mem[{row_lat, col_lat}];
            end
            if (!prev_cas && mem_cas_n) begin
                mon_checks++;
                if (cas_low != T_CAS || !mem_ras_n) begin
                    mon_fails++;
                    $display("FAIL R4 CAS width/R5 rise: got width %0d ras %0b expected %0d ras 1",
                             cas_low, mem_ras_n, T_CAS);
                end
            end
            if (!prev_ras && mem_ras_n) begin
                if (!cas_seen) begin
                    ref_count++;
                    mon_checks++;
                    if (row_lat != exp_ref_row) begin
                        mon_fails++;
                        $display("FAIL R7 refresh row: got %0d expected %0d", row_lat, exp_ref_row);
                    end
                    exp_ref_row = exp_ref_row + 1'b1;
                    mon_checks++;
                    if (ras_low != T_RCD + T_CAS || side_seen) begin
                        mon_fails++;
                        $display("FAIL R6 refresh cycle: got ras_low %0d side %0b expected %0d side 0",
                                 ras_low, side_seen, T_RCD + T_CAS);
                    end
                    mon_checks++;
                    if (fall_cyc - last_ref_cyc > REF_BOUND) begin
                        mon_fails++;
                        $display("FAIL R8 refresh gap: got %0d expected <= %0d", fall_cyc - last_ref_cyc, REF_BOUND);
                    end
                    last_ref_cyc = fall_cyc;
                end
                pre_hi = 0;
            end
            if (mem_ras_n) pre_hi++;
            prev_ras = mem_ras_n;
            prev_cas = mem_cas_n;
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] expect_read(input logic [ADDR_W-1:0] a);
        return exp_mem[a];
    endfunction

    task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= BUSY; k++) begin
            check(!req_ready, "R9 ready low while busy", req_ready, 0);
            if (!wr && k == LAT_RD) begin
                check(rsp_valid, "R3 rsp_valid at read latency", rsp_valid, 1);
                check(rsp_rdata == expect_read(a), "R3 read data", rsp_rdata, expect_read(a));
            end else begin
                check(!rsp_valid, "R3 rsp_valid single pulse", rsp_valid, 0);
            end
            @(negedge clk);
        end
        if (wr) begin
            exp_mem[a] = d;
            check(model_mem[a] == d, "R1 R2 word stored at row/column", model_mem[a], d);
        end
    endtask

    initial begin
        int ref_before;
        n_checks  = 0;
        n_fails   = 0;
        mon_checks = 0;
        mon_fails  = 0;
        timed_out = 1'b0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        for (int i = 0; i < ROWS*ROWS; i++) exp_mem[i] = '0;
        void'($urandom(32'd5171));
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R10 reset state
                check(mem_ras_n && mem_cas_n && mem_we_n, "R10 strobes idle", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
                check(!mem_dq_oe && !rsp_valid, "R10 bus and response idle", {mem_dq_oe, rsp_valid}, 0);
                check(req_ready, "R10 ready after reset", req_ready, 1);

                // directed corners: halves that differ, extremes, unwritten word
                do_op(1'b1, 8'h0F, 8'h5A);
                do_op(1'b1, 8'hF0, 8'hC3);
                do_op(1'b1, 8'h00, 8'hA5);
                do_op(1'b1, 8'hFF, 8'h3C);
                do_op(1'b0, 8'h0F, 8'h00);
                do_op(1'b0, 8'hF0, 8'h00);
                do_op(1'b0, 8'h00, 8'h00);
                do_op(1'b0, 8'hFF, 8'h00);
                do_op(1'b0, 8'h55, 8'h00);

                // back-to-back random traffic; refresh must still win arbitration (R8)
                for (int n = 0; n < 400; n++) begin
                    do_op(1'($urandom % 2), ADDR_W'($urandom), DATA_W'($urandom));
                end
                for (int i = 0; i < ROWS*ROWS; i += 17) do_op(1'b0, ADDR_W'(i), 8'h00);

                // idle window: refreshes continue without traffic
                ref_before = ref_count;
                repeat (4 * REF_INTERVAL) @(negedge clk);
                check(ref_count - ref_before >= 3, "R8 refreshes while idle", ref_count - ref_before, 3);
                check(ref_count > ROWS, "R7 refresh row counter wrapped", ref_count, ROWS + 1);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks + mon_checks, n_fails + mon_fails);
        $finish;
    end

endmodule